// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Register Access

This block is a full-duplex 8-bit serial port. It sits behind a small CPU register bus with two addresses: a data register and a control/status register. It can run as the clock-driving master or as a clocked slave. As master it makes the serial clock by dividing the system clock by a fixed amount. In both roles, writing the data register loads the byte straight into the shift register. There is no transmit buffer. Received bytes are copied into a separate receive buffer, and that buffer is what a data read returns.

A completion flag is raised on the last serial clock of each byte. The flag is cleared by a two-step access: first a control/status read, then a data access. While the flag is pending and that status read has not happened, writes to the data register are dropped. The slave select can come from the external pin or from a software bit. An output-disable bit releases the serial data output.

Top module: `spi_periph`

## Requirements
- R1: In master mode with the port enabled, an accepted data write produces exactly 8 high pulses on `sck_o`. `sck_o` idles low, and consecutive rising edges are 2*HALF system clocks apart.
- R2: Bits leave most-significant first on the active data output. Output data changes after a falling serial clock edge and is stable at every rising edge.
- R3: At each rising serial edge the incoming bit is sampled (`miso_i` as master, `mosi_i` as slave). After the eighth bit, the assembled byte is in the receive buffer and the flag (status bit 7) is 1.
- R4: A data read returns the receive buffer, never the shift register. A data write made after a transfer leaves the read value unchanged.
- R5: While the flag is 1 and no status read has occurred since it was set, data writes are ignored: no transfer starts and the flag stays 1.
- R6: The flag is cleared only by a status read followed by a data access. A data access alone leaves it set, and repeated status reads alone leave it set. A data write that completes the clear is accepted.
- R7: Control bit 4 (output disable) set to 1 forces `mosi_oe` low in master mode and `miso_oe` low in slave mode.
- R8: When enabled, master mode drives `sck_oe` and `mosi_oe` and leaves `miso_oe` low. Slave mode drives `miso_oe` only while selected. `mosi_oe` and `miso_oe` are never both 1.
- R9: With control bit 3 = 0, the slave is selected while `ss_n_i` is low. A selected slave shifts out its loaded byte and receives the master's byte.
- R10: With control bit 3 = 1, the pin is ignored and control bit 2 gives the select level (0 selected, 1 deselected). A deselected slave ignores `sck_i` and `mosi_i`, does not set the flag and does not change the receive buffer.
- R11: Deselecting a slave in the middle of a byte discards the partial bit count, so the next selected byte is received whole.
- R12: The status read layout is: bit 7 flag, bit 6 enable, bit 5 master, bit 4 output disable, bit 3 software select, bit 2 software select level, bits 1..0 zero. After reset it reads 0.
- R13: With enable (control bit 6) at 0, all output enables are low, and a data write in master mode produces no serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 selects data, 1 selects control/status |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the addressed register |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Output enable for the serial clock |
| sck_i | input | 1 | Serial clock received as slave |
| mosi_o | output | 1 | Master data output |
| mosi_oe | output | 1 | Output enable for the master data output |
| mosi_i | input | 1 | Slave data input |
| miso_o | output | 1 | Slave data output |
| miso_oe | output | 1 | Output enable for the slave data output |
| miso_i | input | 1 | Master data input |
| ss_n_i | input | 1 | External slave select, active low |

## Verification
The bench sweeps every byte value through the master and through the slave. A wrong bit order or sampling edge would garble the swept bytes, and a miscounted shift would produce the wrong number of clock pulses. It then walks the flag protocol: a data read without the status read, repeated status reads, and a blocked write followed by an armed write. A design that cleared the flag on either access alone, or let a write through too early, would show a leftover or missing flag, or serial clock activity where none belongs. The bench also cuts a slave byte short by deselecting it, drives the pin against the software select, and loads the shifter after a transfer. A counter that survived deselection, a select source taken from the wrong place, or a data read wired to the shift register would each show up as a wrong received byte.

// File: rtl/spi_pkg.sv
package spi_pkg;

    // register addresses on the CPU bus
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTL  = 1'b1;

    // control fields, stored in status bit order (bit 6 down to bit 2)
    typedef struct packed {
        logic en;     // port enable
        logic mst;    // 1: master, 0: slave
        logic odis;   // release serial data output
        logic ssw;    // select taken from software bit
        logic ssi;    // software select level, 1 = deselected
    } ctl_t;

    // serial edge event fed to the shift engine
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_SAMPLE = 2'd1,
        EV_SHIFT  = 2'd2
    } edge_ev_t;

    function automatic edge_ev_t edge_of(input logic was, input logic now);
        if (!was && now)      return EV_SAMPLE;
        else if (was && !now) return EV_SHIFT;
        else                  return EV_NONE;
    endfunction

endpackage

// File: rtl/spi_sckgen.sv
module spi_sckgen
    import spi_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    output logic     sck,
    output edge_ev_t ev
);
    localparam int HW = $clog2(HALF + 1);

    logic [HW-1:0] cnt_q;
    logic          sck_q;
    logic          tick;

    assign tick = run && (cnt_q == HW'(HALF - 1));
    assign sck  = sck_q;
    assign ev   = tick ? (sck_q ? EV_SHIFT : EV_SAMPLE) : EV_NONE;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: the master clock only moves while a transfer runs
    assert_sck_moves_on_run_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(sck_q) |-> $past(run));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  edge_ev_t      ev,
    input  logic          sin,
    output logic          sout,
    output logic          done,
    output logic [DW-1:0] rx_word
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic          cap_q;
    logic          shift_ok;
    logic          last_bit;

    assign shift_ok = (ev == EV_SHIFT) && !abort;
    assign last_bit = (cnt_q == CW'(DW - 1));
    assign done     = shift_ok && !load && last_bit;
    assign sout     = sh_q[DW-1];
    assign rx_word  = {sh_q[DW-2:0], cap_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
            cap_q <= 1'b0;
        end else begin
            if (load)
                sh_q <= load_val;
            else if (shift_ok)
                sh_q <= {sh_q[DW-2:0], cap_q};

            if (abort)
                cnt_q <= '0;
            else if (shift_ok)
                cnt_q <= last_bit ? '0 : cnt_q + 1'b1;

            if ((ev == EV_SAMPLE) && !abort)
                cap_q <= sin;
        end
    end

    // R11: an aborted count restarts from the first bit
    assert_abort_restarts_R11: assert property (@(posedge clk) disable iff (rst)
        (abort && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/spi_slvsel.sv
module spi_slvsel
    import spi_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ss_n_pin,
    input  logic     sck_pin,
    input  logic     mosi_pin,
    input  logic     ssw,
    input  logic     ssi,
    output logic     sel,
    output edge_ev_t ev,
    output logic     mosi_s
);
    logic [SYNC-1:0] ss_p, sck_p, mo_p;
    logic            sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_p     <= '1;
            sck_p    <= '0;
            mo_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            ss_p     <= {ss_p[SYNC-2:0], ss_n_pin};
            sck_p    <= {sck_p[SYNC-2:0], sck_pin};
            mo_p     <= {mo_p[SYNC-2:0], mosi_pin};
            sck_last <= sck_p[SYNC-1];
        end
    end

    assign sel    = ssw ? ~ssi : ~ss_p[SYNC-1];
    assign mosi_s = mo_p[SYNC-1];
    assign ev     = sel ? edge_of(sck_last, sck_p[SYNC-1]) : EV_NONE;

endmodule

// File: rtl/spi_periph.sv
module spi_periph
    import spi_pkg::*;
#(
    parameter int DW   = 8,
    parameter int HALF = 2,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          sck_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          miso_i,
    input  logic          ss_n_i
);
    localparam int CTLW = $bits(ctl_t);
    localparam int PADW = DW - 1 - CTLW;

    ctl_t          ctl_q;
    logic          flag_q, arm_q, busy_q;
    logic [DW-1:0] rx_buf;

    logic          wr_data, rd_data, rd_ctl, wr_ctl, acc_data;
    logic          wr_ok, start, load, abort, done;
    logic          slv_sel, slv_mosi, sout, sin;
    edge_ev_t      mst_ev, slv_ev, ev;
    logic [DW-1:0] rx_word;

    assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
    assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
    assign wr_ctl   = bus_wr && (bus_addr == ADDR_CTL);
    assign rd_ctl   = bus_rd && (bus_addr == ADDR_CTL);
    assign acc_data = wr_data || rd_data;

    assign wr_ok = wr_data && (!flag_q || arm_q);
    assign start = wr_ok && ctl_q.en && ctl_q.mst && !busy_q;
    assign load  = wr_ok && !(ctl_q.mst && busy_q);
    assign abort = !ctl_q.en || (!ctl_q.mst && !slv_sel);
    assign ev    = ctl_q.mst ? mst_ev : slv_ev;
    assign sin   = ctl_q.mst ? miso_i : slv_mosi;

    spi_sckgen #(.HALF(HALF)) u_sck (
        .clk (clk),
        .rst (rst),
        .run (busy_q && ctl_q.mst),
        .sck (sck_o),
        .ev  (mst_ev)
    );

    spi_slvsel #(.SYNC(SYNC)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .ss_n_pin (ss_n_i),
        .sck_pin  (sck_i),
        .mosi_pin (mosi_i),
        .ssw      (ctl_q.ssw),
        .ssi      (ctl_q.ssi),
        .sel      (slv_sel),
        .ev       (slv_ev),
        .mosi_s   (slv_mosi)
    );

    spi_shifter #(.DW(DW)) u_sh (
        .clk      (clk),
        .rst      (rst),
        .abort    (abort),
        .load     (load),
        .load_val (bus_wdata),
        .ev       (ev),
        .sin      (sin),
        .sout     (sout),
        .done     (done),
        .rx_word  (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
            busy_q <= 1'b0;
            rx_buf <= '0;
        end else begin
            if (wr_ctl)
                ctl_q <= ctl_t'(bus_wdata[DW-2 -: CTLW]);

            if (done) begin
                flag_q <= 1'b1;
                arm_q  <= 1'b0;
                rx_buf <= rx_word;
            end else if (flag_q && arm_q && acc_data) begin
                flag_q <= 1'b0;
                arm_q  <= 1'b0;
            end else if (flag_q && rd_ctl) begin
                arm_q  <= 1'b1;
            end

            if (!ctl_q.en)
                busy_q <= 1'b0;
            else if (start)
                busy_q <= 1'b1;
            else if (done)
                busy_q <= 1'b0;
        end
    end

    assign bus_rdata = (bus_addr == ADDR_CTL) ? {flag_q, ctl_q, {PADW{1'b0}}} : rx_buf;

    assign sck_oe  = ctl_q.en && ctl_q.mst;
    assign mosi_o  = sout;
    assign mosi_oe = ctl_q.en && ctl_q.mst && !ctl_q.odis;
    assign miso_o  = sout;
    assign miso_oe = ctl_q.en && !ctl_q.mst && slv_sel && !ctl_q.odis;

    // R3: a finished byte always raises the flag
    assert_done_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> flag_q);

    // R4: the receive buffer only changes on completion
    assert_rxbuf_holds_R4: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(rx_buf));

    // R5: an unarmed write while the flag is pending starts nothing
    assert_blocked_write_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en && ctl_q.mst && !busy_q && flag_q && !arm_q && wr_data) |=> !busy_q);

    // R6: the flag only drops after a status read armed it
    assert_flag_clear_armed_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(arm_q));

    // R8: the two data outputs are never driven together
    assert_no_dual_drive_R8: assert property (@(posedge clk) disable iff (rst)
        !(mosi_oe && miso_oe));

    // R10: a deselected slave never completes a byte
    assert_desel_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en && !ctl_q.mst && !slv_sel) |-> !done);

endmodule

// File: tb/sim_spi_periph.sv
module sim_spi_periph;
    localparam int DW   = 8;
    localparam int HALF = 2;
    localparam int HB   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic          sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    spi_periph #(.DW(DW), .HALF(HALF), .SYNC(2)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // bench plays slave to the master: returns bits seen on mosi_o, rise count, period error
    task automatic mst_run(input logic [7:0] resp, output logic [7:0] got,
                           output int rises, output int per_err);
        int falls = 0;
        int since = 0;
        logic prev;
        rises = 0; per_err = 0; got = '0;
        prev = sck_o;
        for (int c = 0; c < 40 * HALF + 20 && falls < 8; c++) begin
            @(negedge clk);
            since++;
            if (!prev && sck_o) begin
                if (rises > 0 && since != 2 * HALF) per_err++;
                since = 0;
                rises++;
                got = {got[6:0], mosi_o};
            end else if (prev && !sck_o) begin
                falls++;
                if (falls < 8) miso_i = resp[7 - falls];
            end
            prev = sck_o;
        end
        repeat (3) @(negedge clk);
    endtask

    // count master clock rises over a quiet window
    task automatic quiet(input int n, output int rises);
        logic prev;
        rises = 0;
        prev = sck_o;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (!prev && sck_o) rises++;
            prev = sck_o;
        end
    endtask

    // bench plays master to the slave for n bits
    task automatic slv_bits(input logic [7:0] tx, input int n, output logic [7:0] got);
        got = '0;
        for (int b = 0; b < n; b++) begin
            mosi_i = tx[7 - b];
            repeat (HB) @(negedge clk);
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            repeat (HB) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (HB) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, got, resp, tx;
        int rises, perr;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        bread(1'b1, rd);
        check(rd == 8'h00, "R12 status after reset", rd, 0);
        check({sck_oe, mosi_oe, miso_oe, sck_o} == 4'b0, "R13 oe after reset",
              {sck_oe, mosi_oe, miso_oe, sck_o}, 0);

        // disabled master: no clock
        bwrite(1'b1, 8'h20);
        check({sck_oe, mosi_oe, miso_oe} == 3'b0, "R13 oe disabled", {sck_oe, mosi_oe, miso_oe}, 0);
        bwrite(1'b0, 8'h55);
        quiet(40, rises);
        check(rises == 0, "R13 no sck when disabled", rises, 0);

        // enabled master
        bwrite(1'b1, 8'h60);
        check({sck_oe, mosi_oe, miso_oe} == 3'b110, "R8 master oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);
        bread(1'b1, rd);
        check(rd == 8'h60, "R12 status layout master", rd, 8'h60);

        // full sweep as master
        for (int v = 0; v < 256; v++) begin
            resp = ~v[7:0] ^ 8'h3C;
            miso_i = resp[7];
            bwrite(1'b0, v[7:0]);
            mst_run(resp, got, rises, perr);
            check(rises == 8, "R1 eight sck pulses", rises, 8);
            check(perr == 0 && sck_o == 1'b0, "R1 sck period and idle", perr, 0);
            check(got == v[7:0], "R2 msb-first mosi", got, v);
            bread(1'b1, rd);
            check(rd == 8'hE0, "R3 R12 flag set", rd, 8'hE0);
            bread(1'b0, rd);
            check(rd == resp, "R3 master received byte", rd, resp);
        end
        bread(1'b1, rd);
        check(rd[7] == 1'b0, "R6 flag cleared after sequence", rd[7], 0);

        // R6: data access alone, status reads alone
        resp = 8'h96; miso_i = resp[7];
        bwrite(1'b0, 8'h11);
        mst_run(resp, got, rises, perr);
        bread(1'b0, rd);
        bread(1'b1, rd);
        check(rd[7] == 1'b1, "R6 data read alone keeps flag", rd[7], 1);
        bread(1'b1, rd);
        check(rd[7] == 1'b1, "R6 status reads alone keep flag", rd[7], 1);
        bread(1'b0, rd);
        bread(1'b1, rd);
        check(rd[7] == 1'b0, "R6 status then data clears", rd[7], 0);

        // R5: blocked write, then armed write accepted
        resp = 8'h5A; miso_i = resp[7];
        bwrite(1'b0, 8'h22);
        mst_run(resp, got, rises, perr);
        bwrite(1'b0, 8'h3C);
        quiet(40, rises);
        check(rises == 0, "R5 blocked write starts nothing", rises, 0);
        bread(1'b1, rd);
        check(rd[7] == 1'b1, "R5 flag still pending", rd[7], 1);
        resp = 8'hC7; miso_i = resp[7];
        bwrite(1'b0, 8'h3C);
        mst_run(resp, got, rises, perr);
        check(rises == 8 && got == 8'h3C, "R6 armed write accepted", got, 8'h3C);
        bread(1'b1, rd);
        bread(1'b0, rd);
        check(rd == 8'hC7, "R3 received after armed write", rd, 8'hC7);

        // R7 master output disable
        bwrite(1'b1, 8'h70);
        check(sck_oe == 1'b1 && mosi_oe == 1'b0, "R7 master mosi released", mosi_oe, 0);

        // R4: load shifter in deselected slave, buffer unchanged
        ss_n_i = 1'b1;
        bwrite(1'b1, 8'h40);
        bwrite(1'b0, 8'h81);
        bread(1'b0, rd);
        check(rd == 8'hC7, "R4 read returns buffer", rd, 8'hC7);
        check(miso_oe == 1'b0, "R8 deselected slave quiet", miso_oe, 0);

        // slave sweep with pin select
        for (int v = 0; v < 256; v++) begin
            tx = v[7:0] ^ 8'h5A;
            bwrite(1'b0, tx);
            ss_n_i = 1'b0;
            repeat (4) @(negedge clk);
            check(miso_oe == 1'b1 && mosi_oe == 1'b0, "R8 R9 slave drives miso", miso_oe, 1);
            slv_bits(v[7:0], 8, got);
            ss_n_i = 1'b1;
            check(got == tx, "R9 slave shifted out", got, tx);
            bread(1'b1, rd);
            check(rd == 8'hC0, "R3 R12 slave flag", rd, 8'hC0);
            bread(1'b0, rd);
            check(rd == v[7:0], "R9 slave received", rd, v);
        end

        // R7 slave output disable
        ss_n_i = 1'b0;
        bwrite(1'b1, 8'h50);
        repeat (4) @(negedge clk);
        check(miso_oe == 1'b0, "R7 slave miso released", miso_oe, 0);
        ss_n_i = 1'b1;

        // R10 software select, pin deasserted
        bwrite(1'b1, 8'h48);
        bwrite(1'b0, 8'hA1);
        repeat (4) @(negedge clk);
        check(miso_oe == 1'b1, "R10 software select drives", miso_oe, 1);
        slv_bits(8'h6E, 8, got);
        check(got == 8'hA1, "R10 software select shifts", got, 8'hA1);
        bread(1'b1, rd);
        check(rd == 8'hC8, "R10 R12 flag sw select", rd, 8'hC8);
        bread(1'b0, rd);
        check(rd == 8'h6E, "R10 received sw select", rd, 8'h6E);

        // R10 software deselect overrides a low pin
        ss_n_i = 1'b0;
        bwrite(1'b1, 8'h4C);
        repeat (4) @(negedge clk);
        check(miso_oe == 1'b0, "R10 sw deselect quiet", miso_oe, 0);
        slv_bits(8'h13, 8, got);
        bread(1'b1, rd);
        check(rd[7] == 1'b0, "R10 no flag when deselected", rd[7], 0);
        bread(1'b0, rd);
        check(rd == 8'h6E, "R10 buffer unchanged", rd, 8'h6E);

        // R11 partial byte then deselect
        ss_n_i = 1'b1;
        bwrite(1'b1, 8'h40);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        slv_bits(8'hFF, 3, got);
        ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
        bread(1'b1, rd);
        check(rd[7] == 1'b0, "R11 partial byte no flag", rd[7], 0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        slv_bits(8'hC3, 8, got);
        ss_n_i = 1'b1;
        bread(1'b1, rd);
        check(rd[7] == 1'b1, "R11 flag after whole byte", rd[7], 1);
        bread(1'b0, rd);
        check(rd == 8'hC3, "R11 whole byte received", rd, 8'hC3);

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule